// File: doc/BRIEF.md
# Erased-Page Aware ECC Outcome Classifier

This block sits next to the read path of a flash page controller. While a page streams out, it looks at every byte of the main data area and of the spare (tag) area and remembers, per area, whether any byte differed from 0xFF. When the page ends, it combines these two facts with the uncorrectable-error flags that a separate ECC decoder raises for each area. The result is a two-bit verdict.

A freshly erased page holds nothing but 0xFF. Such a page cannot carry valid check symbols, so the decoder flags it as uncorrectable. This block suppresses that false alarm: an area that is fully erased is never reported as failing. The data and tag areas are judged independently. The verdict is only meaningful when the decoder's global error flag was raised for the page.

The data-area length is selectable as 512, 2048 or 4096 bytes. The checked tag window is 1 to 64 bytes long. Optionally, a fixed number of leading spare bytes is skipped before the tag window begins.

Top module: `ecc_blank_judge`

## Requirements
- R1: After reset, `result` is 2'b00 and `result_vld` is low.
- R2: `result_vld` goes high for exactly one clock, in the cycle after a clock in which `eop` was high and `sop` was low. `result` carries the verdict in that same cycle.
- R3: If `ecc_irq` is low in the `eop` cycle, `result` is 2'b00 whatever `fail_a` and `fail_b` say.
- R4: `result[1]` (data error) is 1 only when all of the following hold in the `eop` cycle: `ecc_irq` is high, `fail_a` is high, and at least one counted data-area byte (`byte_area`=0) was not 0xFF.
- R5: `result[0]` (tag error) is 1 only when all of the following hold in the `eop` cycle: `ecc_irq` is high, `fail_b` is high, and at least one tag byte inside the checked window (`byte_area`=1) was not 0xFF.
- R6: Both result bits may be set together when both areas fail and both hold non-0xFF bytes.
- R7: When `tag_skip_en` is 1, the first 4 spare bytes of the page are outside the checked tag window. When it is 0, the window starts at spare byte 0.
- R8: Only the first N data bytes of a page are checked. N is 512 for `data_len_sel`=2'b00, 2048 for 2'b01, and 4096 for 2'b10 or 2'b11. Later data bytes are ignored.
- R9: The checked tag window is `tag_len` bytes long (1..64). Spare bytes after the window are ignored.
- R10: Between verdicts, `result` holds its value. A `sop` pulse clears it to 2'b00 in the following cycle.
- R11: `sop` restarts the erased tracking of both areas, so non-0xFF bytes of an earlier page do not affect the next verdict.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sop | input | 1 | Start-of-page strobe |
| eop | input | 1 | End-of-page strobe; samples the ECC flags |
| byte_vld | input | 1 | A page byte is present on `byte_val` |
| byte_area | input | 1 | 0 = data area, 1 = spare/tag area |
| byte_val | input | 8 | Page byte |
| data_len_sel | input | 2 | Data-area length select |
| tag_len | input | 7 | Checked tag window length, 1..64 |
| tag_skip_en | input | 1 | Skip leading spare bytes before the tag window |
| ecc_irq | input | 1 | Decoder's global ECC error flag |
| fail_a | input | 1 | Uncorrectable failure in data area |
| fail_b | input | 1 | Uncorrectable failure in tag area |
| result | output | 2 | Bit 1 = data error, bit 0 = tag error |
| result_vld | output | 1 | One-clock pulse marking a new verdict |

## Verification
The bench uses the default parameters: a 4-byte skip, a 64-byte tag ceiling and a 4096-byte data ceiling. These defaults make every data-length select reachable, including the largest page.

Directed pages place a single non-0xFF byte just inside and just outside each window edge: the skip boundary, the end of the tag window, and the data length. Random pages vary the length selects, the skip enable, the flags and the positions of corrupted bytes. The random stream mostly uses the shortest data length, so that many pages fit in the run.

// File: rtl/ecc_blank_judge.sv
`timescale 1ns/1ps
module ecc_blank_judge #(
  parameter int SKIP_BYTES = 4,
  parameter int TAG_MAX    = 64,
  parameter int DATA_MAX   = 4096
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sop,
  input  logic                         eop,
  input  logic                         byte_vld,
  input  logic                         byte_area,
  input  logic [7:0]                   byte_val,
  input  logic [1:0]                   data_len_sel,
  input  logic [$clog2(TAG_MAX+1)-1:0] tag_len,
  input  logic                         tag_skip_en,
  input  logic                         ecc_irq,
  input  logic                         fail_a,
  input  logic                         fail_b,
  output logic [1:0]                   result,
  output logic                         result_vld
);
  localparam int DCW = $clog2(DATA_MAX + 1);
  localparam int TCW = $clog2(TAG_MAX + SKIP_BYTES + 1);
  localparam int LW  = $clog2(TAG_MAX + 1);

  logic [DCW-1:0] d_cnt, d_lim;
  logic [TCW-1:0] t_cnt, t_lo, t_hi;
  logic           d_blank, t_blank, d_blank_nx, t_blank_nx;
  logic           d_take, t_adv, t_take, not_ff;

  always_comb begin
    case (data_len_sel)
      2'b00:   d_lim = DCW'(DATA_MAX / 8);
      2'b01:   d_lim = DCW'(DATA_MAX / 2);
      default: d_lim = DCW'(DATA_MAX);
    endcase
  end

  assign not_ff     = byte_val != 8'hFF;
  assign t_lo       = tag_skip_en ? TCW'(SKIP_BYTES) : '0;
  assign t_hi       = t_lo + TCW'(tag_len);
  assign d_take     = byte_vld && !byte_area && (d_cnt < d_lim);
  assign t_adv      = byte_vld && byte_area && (t_cnt < t_hi);
  assign t_take     = t_adv && (t_cnt >= t_lo);
  assign d_blank_nx = d_blank && !(d_take && not_ff);
  assign t_blank_nx = t_blank && !(t_take && not_ff);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d_cnt      <= '0;
      t_cnt      <= '0;
      d_blank    <= 1'b1;
      t_blank    <= 1'b1;
      result     <= 2'b00;
      result_vld <= 1'b0;
    end else begin
      result_vld <= eop && !sop;
      if (sop) begin
        d_cnt   <= '0;
        t_cnt   <= '0;
        d_blank <= 1'b1;
        t_blank <= 1'b1;
        result  <= 2'b00;
      end else begin
        if (d_take) d_cnt <= d_cnt + 1'b1;
        if (t_adv)  t_cnt <= t_cnt + 1'b1;
        d_blank <= d_blank_nx;
        t_blank <= t_blank_nx;
        if (eop)
          result <= {ecc_irq && fail_a && !d_blank_nx,
                     ecc_irq && fail_b && !t_blank_nx};
      end
    end
  end

  logic unused_ok;
  assign unused_ok = &{1'b0, LW[0]};
endmodule

// File: rtl/ecc_blank_judge_chk.sv
`timescale 1ns/1ps
module ecc_blank_judge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sop,
  input logic       eop,
  input logic       ecc_irq,
  input logic       fail_a,
  input logic       fail_b,
  input logic [1:0] result,
  input logic       result_vld
);
  p_vld_follows_eop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !sop) |=> result_vld);
  p_vld_only_after_eop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!eop || sop) |=> !result_vld);
  p_no_irq_ok_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !sop && !ecc_irq) |=> (result == 2'b00));
  p_data_needs_fail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !sop && !fail_a) |=> !result[1]);
  p_tag_needs_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eop && !sop && !fail_b) |=> !result[0]);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sop && !eop) |=> $stable(result));
  p_sop_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sop |=> (result == 2'b00 && !result_vld));
endmodule

bind ecc_blank_judge ecc_blank_judge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sop(sop), .eop(eop), .ecc_irq(ecc_irq),
  .fail_a(fail_a), .fail_b(fail_b), .result(result), .result_vld(result_vld)
);

// File: tb/sim_ecc_blank_judge.sv
`timescale 1ns/1ps
module sim_ecc_blank_judge;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       sop = 0, eop = 0, byte_vld = 0, byte_area = 0;
  logic [7:0] byte_val = 8'hFF;
  logic [1:0] data_len_sel = 0;
  logic [6:0] tag_len = 7'd20;
  logic       tag_skip_en = 1'b1, ecc_irq = 0, fail_a = 0, fail_b = 0;
  logic [1:0] result;
  logic       result_vld;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ecc_blank_judge u0 (.*);

  task automatic chk(string req, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int dlen_of(int sel);
    return sel == 0 ? 512 : (sel == 1 ? 2048 : 4096);
  endfunction

  function automatic int exp_res(int sel, int tl, bit sk, int pd, int pt,
                                 bit irq, bit fa, bit fb);
    int lo = sk ? 4 : 0;
    bit dbad = (pd >= 0) && (pd < dlen_of(sel));
    bit tbad = (pt >= lo) && (pt < lo + tl);
    return {irq & fa & dbad, irq & fb & tbad};
  endfunction

  task automatic page(string req, int sel, int tl, bit sk, int nd, int nt,
                      int pd, int pt, bit irq, bit fa, bit fb);
    int e;
    logic [1:0] held;
    @(negedge clk);
    data_len_sel = 2'(sel); tag_len = 7'(tl); tag_skip_en = sk;
    sop = 1;
    @(negedge clk);
    sop = 0;
    chk("R10 sop clear", int'(result), 0);
    chk("R2 no vld after sop", int'(result_vld), 0);
    for (int i = 0; i < nd; i++) begin
      byte_vld = 1; byte_area = 0;
      byte_val = (i == pd) ? 8'($urandom_range(0, 254)) : 8'hFF;
      @(negedge clk);
    end
    for (int i = 0; i < nt; i++) begin
      byte_vld = 1; byte_area = 1;
      byte_val = (i == pt) ? 8'($urandom_range(0, 254)) : 8'hFF;
      @(negedge clk);
      if ($urandom_range(0, 3) == 0) begin byte_vld = 0; @(negedge clk); end
    end
    byte_vld = 0;
    eop = 1; ecc_irq = irq; fail_a = fa; fail_b = fb;
    @(negedge clk);
    eop = 0; ecc_irq = 0; fail_a = 0; fail_b = 0;
    e = exp_res(sel, tl, sk, pd, pt, irq, fa, fb);
    chk("R2 vld pulse", int'(result_vld), 1);
    chk(req, int'(result), e);
    held = result;
    @(negedge clk);
    chk("R2 vld one cycle", int'(result_vld), 0);
    repeat (3) @(negedge clk);
    chk("R10 hold", int'(result), int'(held));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset vld", int'(result_vld), 0);
    rst_n = 1;
    void'($urandom(32'd4242));
    page("R3 no irq",          0, 20, 1, 512, 24, 10, 8, 0, 1, 1);
    page("R4 R5 erased",       0, 20, 1, 512, 24, -1, -1, 1, 1, 1);
    page("R4 data error",      0, 20, 1, 512, 24, 100, -1, 1, 1, 0);
    page("R11 fresh page",     0, 20, 1, 512, 24, -1, -1, 1, 1, 1);
    page("R4 no fail_a",       0, 20, 1, 512, 24, 100, -1, 1, 0, 0);
    page("R5 tag error",       0, 20, 1, 512, 24, -1, 5, 1, 0, 1);
    page("R6 both",            0, 20, 1, 512, 24, 0, 10, 1, 1, 1);
    page("R7 skipped byte",    0, 20, 1, 512, 24, -1, 2, 1, 1, 1);
    page("R7 skip off",        0, 20, 0, 512, 24, -1, 2, 1, 1, 1);
    page("R7 first after skip",0, 20, 1, 512, 24, -1, 4, 1, 1, 1);
    page("R8 past 512",        0, 20, 1, 600, 24, 550, -1, 1, 1, 1);
    page("R8 last of 512",     0, 20, 1, 600, 24, 511, -1, 1, 1, 1);
    page("R8 2048",            1, 20, 1, 2100, 24, 1500, -1, 1, 1, 1);
    page("R8 past 2048",       1, 20, 1, 2100, 24, 2048, -1, 1, 1, 1);
    page("R8 4096",            2, 20, 1, 4096, 24, 4095, -1, 1, 1, 1);
    page("R9 past window",     0, 16, 1, 512, 30, -1, 20, 1, 1, 1);
    page("R9 window end",      0, 16, 1, 512, 30, -1, 19, 1, 1, 1);
    page("R9 len 1",           0, 1, 0, 512, 4, -1, 0, 1, 1, 1);
    page("R9 len 64",          0, 64, 1, 512, 70, -1, 67, 1, 1, 1);
    for (int k = 0; k < 30; k++) begin
      int sel = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 3)) : 0;
      int tl  = int'($urandom_range(1, 64));
      bit sk  = 1'($urandom_range(0, 1));
      int nd  = dlen_of(sel) + int'($urandom_range(0, 8));
      int nt  = (sk ? 4 : 0) + tl + int'($urandom_range(0, 4));
      int pd  = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, nd - 1)) : -1;
      int pt  = ($urandom_range(0, 1) == 1) ? int'($urandom_range(0, nt - 1)) : -1;
      page("R4 R5 R6 random", sel, tl, sk, nd, nt, pd, pt,
           1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 1)),
           1'($urandom_range(0, 1)));
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (190000) @(negedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule